// File: doc/BRIEF.md
# Swap-Posted Interrupt Register

This block is the single interrupt mailbox of one processing module. Anyone who wants to interrupt the module's processor (the local processor, a remote processor or a device) posts an atomic swap. The swap carries a 32-bit word and gets back the word the register held just before it. If nothing is pending, a nonzero word is stored and the processor interrupt line goes high. If an interrupt is already pending, the register keeps its contents and the swap returns the pending word. The requester therefore learns from the returned word alone whether its interrupt was taken: all zeros means it was accepted, and a nonzero word means the mailbox was busy and the swap should be retried later.

The service routine reads the stored word from a dedicated read port. The word is typically a handler pointer or a code for the device and the event. The routine then pulses a clear strobe, which empties the register and drops the interrupt line. All zeros is reserved as the "empty" value, so a swap of zero never posts anything. A clear and a swap in the same cycle are ordered clear-first, so the swap lands in an emptied register. The asynchronous active-low reset is released synchronously inside the block.

Top module: `swap_irq_reg`

## Requirements
- R1: While reset is asserted, and in the first cycle after its synchronised release, `irq` is 0, `isr_word` is 0 and `swap_ack` is 0. Asserting reset drops `irq` at once, without waiting for a clock edge.
- R2: A swap with a nonzero word into an empty register stores the word. From the next cycle, `irq` is 1 and `isr_word` equals the word.
- R3: `swap_ack` is high in exactly the cycle after each cycle with `swap_req` high, and low otherwise.
- R4: The word returned on `swap_old` with a successful swap is all zeros.
- R5: A swap while an interrupt is pending leaves `irq` and `isr_word` unchanged and returns the pending word on `swap_old`.
- R6: A swap of the all-zeros word never changes `irq` or `isr_word`. It returns the current contents (zero when empty).
- R7: A clear strobe with no swap in the same cycle makes `irq` 0 and `isr_word` 0 from the next cycle.
- R8: When a clear and a swap arrive in the same cycle, the clear acts first. A nonzero swap is then accepted and returns zero, and a zero swap leaves the register empty.
- R9: `irq` is a level: it stays 1 on every cycle until a clear, and `irq` is 1 exactly when `isr_word` is nonzero.
- R10: A clear strobe while the register is empty has no effect on `irq` or `isr_word`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| swap_req | input | 1 | One-cycle swap request |
| swap_data | input | 32 | Word offered by the swap |
| swap_ack | output | 1 | Swap response valid, one cycle after `swap_req` |
| swap_old | output | 32 | Word returned by the swap (zero = accepted) |
| isr_clr | input | 1 | Clear strobe from the service routine |
| isr_word | output | 32 | Stored interrupt word, zero when empty |
| irq | output | 1 | Interrupt level to the processor |

## Verification
Every result is registered once. A swap or clear driven before edge N shows up on `irq`, `isr_word`, `swap_ack` and `swap_old` right after edge N. The only exception is the reset drop of `irq`, which happens without a clock. The bench drives each vector on a falling edge and compares all outputs on the following falling edge, one rising edge later. It checks `swap_old` only in cycles where `swap_ack` is high. After the synchronised reset release, the bench waits for the synchroniser stages to pass before it offers the first swap.

// File: rtl/swap_irq_pkg.sv
package swap_irq_pkg;

  localparam int unsigned WORD_W = 32;

  typedef logic [WORD_W-1:0] word_t;

  // all-zeros is the reserved "empty" value and can never be posted
  function automatic logic is_postable(input word_t w);
    return |w;
  endfunction

endpackage

// File: rtl/swap_irq_rst_sync.sv
module swap_irq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/swap_irq_decide.sv
module swap_irq_decide
  import swap_irq_pkg::*;
(
  input  logic  pend_q,
  input  word_t payload_q,
  input  logic  swap_req,
  input  word_t swap_data,
  input  logic  isr_clr,
  output logic  accept,
  output word_t old_word
);

  logic pend_after_clr;

  always_comb begin
    // clear is ordered ahead of any swap in the same cycle
    pend_after_clr = pend_q & ~isr_clr;
    accept         = swap_req & ~pend_after_clr & is_postable(swap_data);
    old_word       = pend_after_clr ? payload_q : '0;
  end

endmodule

// File: rtl/swap_irq_store.sv
module swap_irq_store
  import swap_irq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  accept,
  input  logic  isr_clr,
  input  word_t swap_data,
  output logic  pend_q,
  output word_t payload_q
);

  logic  pend_d;
  word_t payload_d;
  logic  store_en;

  always_comb begin
    pend_d    = pend_q;
    payload_d = payload_q;
    if (isr_clr) begin
      pend_d    = 1'b0;
      payload_d = '0;
    end
    if (accept) begin
      pend_d    = 1'b1;
      payload_d = swap_data;
    end
    store_en = isr_clr | accept;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q    <= 1'b0;
      payload_q <= '0;
    end else if (store_en) begin
      pend_q    <= pend_d;
      payload_q <= payload_d;
    end
  end

endmodule

// File: rtl/swap_irq_resp.sv
module swap_irq_resp
  import swap_irq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  swap_req,
  input  word_t old_word,
  output logic  ack_q,
  output word_t old_q
);

  word_t old_d;

  always_comb begin
    old_d = swap_req ? old_word : old_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q <= 1'b0;
      old_q <= '0;
    end else begin
      ack_q <= swap_req;
      if (swap_req) begin
        old_q <= old_d;
      end
    end
  end

endmodule

// File: rtl/swap_irq_reg.sv
module swap_irq_reg
  import swap_irq_pkg::*;
#(
  parameter int unsigned RST_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        swap_req,
  input  logic [31:0] swap_data,
  output logic        swap_ack,
  output logic [31:0] swap_old,
  input  logic        isr_clr,
  output logic [31:0] isr_word,
  output logic        irq
);

  logic  rst_sync_n;
  logic  pend_q;
  word_t payload_q;
  logic  accept;
  word_t old_word;

  swap_irq_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  swap_irq_decide u_decide (
    .pend_q    (pend_q),
    .payload_q (payload_q),
    .swap_req  (swap_req),
    .swap_data (swap_data),
    .isr_clr   (isr_clr),
    .accept    (accept),
    .old_word  (old_word)
  );

  swap_irq_store u_store (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .accept    (accept),
    .isr_clr   (isr_clr),
    .swap_data (swap_data),
    .pend_q    (pend_q),
    .payload_q (payload_q)
  );

  swap_irq_resp u_resp (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .swap_req (swap_req),
    .old_word (old_word),
    .ack_q    (swap_ack),
    .old_q    (swap_old)
  );

  assign isr_word = payload_q;
  assign irq      = pend_q;

endmodule

// File: rtl/swap_irq_reg_chk.sv
module swap_irq_reg_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        swap_req,
  input logic [31:0] swap_data,
  input logic        swap_ack,
  input logic [31:0] swap_old,
  input logic        isr_clr,
  input logic [31:0] isr_word,
  input logic        irq
);

  // R3
  ack_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swap_req |=> swap_ack);

  // R3
  no_stray_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !swap_req |=> !swap_ack);

  // R2
  post_stores_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && swap_req && (swap_data != 32'd0)) |=> (irq && isr_word == $past(swap_data)));

  // R4
  post_returns_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && swap_req && (swap_data != 32'd0)) |=> (swap_old == 32'd0));

  // R5
  busy_keeps_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !isr_clr && swap_req) |=> ($stable(isr_word) && swap_old == $past(isr_word)));

  // R7
  clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (isr_clr && !swap_req) |=> (!irq && isr_word == 32'd0));

  // R9
  level_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !isr_clr) |=> irq);

  // R9
  level_matches_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (isr_word != 32'd0));

endmodule

bind swap_irq_reg swap_irq_reg_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .swap_req  (swap_req),
  .swap_data (swap_data),
  .swap_ack  (swap_ack),
  .swap_old  (swap_old),
  .isr_clr   (isr_clr),
  .isr_word  (isr_word),
  .irq       (irq)
);

// File: tb/swap_irq_reg_tb.sv
`timescale 1ns/1ps
module swap_irq_reg_tb;

  logic        clk;
  logic        rst_n;
  logic        swap_req;
  logic [31:0] swap_data;
  logic        swap_ack;
  logic [31:0] swap_old;
  logic        isr_clr;
  logic [31:0] isr_word;
  logic        irq;

  int n_chk;
  int n_bad;
  bit done;

  swap_irq_reg u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .swap_req  (swap_req),
    .swap_data (swap_data),
    .swap_ack  (swap_ack),
    .swap_old  (swap_old),
    .isr_clr   (isr_clr),
    .isr_word  (isr_word),
    .irq       (irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // {req, clr, data[32], exp_irq, exp_ack, exp_isr[32], exp_old[32], tag[4]}
  localparam int NV = 13;
  localparam logic [103:0] VEC [NV] = '{
    {1'b1, 1'b0, 32'hA5A5_0001, 1'b1, 1'b1, 32'hA5A5_0001, 32'h0000_0000, 4'd2},  // R2 R4 post into empty
    {1'b0, 1'b0, 32'h0000_0000, 1'b1, 1'b0, 32'hA5A5_0001, 32'h0000_0000, 4'd9},  // R9 level held
    {1'b1, 1'b0, 32'h1234_5678, 1'b1, 1'b1, 32'hA5A5_0001, 32'hA5A5_0001, 4'd5},  // R5 busy
    {1'b1, 1'b0, 32'h0000_0000, 1'b1, 1'b1, 32'hA5A5_0001, 32'hA5A5_0001, 4'd6},  // R6 zero while busy
    {1'b0, 1'b1, 32'h0000_0000, 1'b0, 1'b0, 32'h0000_0000, 32'h0000_0000, 4'd7},  // R7 clear
    {1'b0, 1'b1, 32'h0000_0000, 1'b0, 1'b0, 32'h0000_0000, 32'h0000_0000, 4'd10}, // R10 clear when empty
    {1'b1, 1'b0, 32'h0000_0000, 1'b0, 1'b1, 32'h0000_0000, 32'h0000_0000, 4'd6},  // R6 zero while empty
    {1'b1, 1'b0, 32'hDEAD_BEEF, 1'b1, 1'b1, 32'hDEAD_BEEF, 32'h0000_0000, 4'd4},  // R4 accepted
    {1'b1, 1'b1, 32'h0000_0042, 1'b1, 1'b1, 32'h0000_0042, 32'h0000_0000, 4'd8},  // R8 clear+swap
    {1'b0, 1'b0, 32'h0000_0000, 1'b1, 1'b0, 32'h0000_0042, 32'h0000_0000, 4'd3},  // R3 no ack
    {1'b1, 1'b1, 32'h0000_0000, 1'b0, 1'b1, 32'h0000_0000, 32'h0000_0000, 4'd8},  // R8 clear+zero swap
    {1'b1, 1'b0, 32'hFFFF_FFFF, 1'b1, 1'b1, 32'hFFFF_FFFF, 32'h0000_0000, 4'd2},  // R2 all ones
    {1'b1, 1'b0, 32'h0000_0001, 1'b1, 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'd3}   // R3 back-to-back ack, R5
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic rq, input logic cl, input logic [31:0] d);
    swap_req  = rq;
    isr_clr   = cl;
    swap_data = d;
  endtask

  initial begin
    repeat (10000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    n_chk = 0;
    n_bad = 0;
    done  = 1'b0;
    rst_n = 1'b0;
    drive(1'b0, 1'b0, 32'd0);
    repeat (3) @(negedge clk);
    // R1 outputs during reset
    check("R1 irq in reset", {31'd0, irq}, 32'd0);
    check("R1 isr_word in reset", isr_word, 32'd0);
    check("R1 ack in reset", {31'd0, swap_ack}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 irq after release", {31'd0, irq}, 32'd0);
    repeat (3) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [103:0] v;
      string        tg;
      v  = VEC[i];
      tg = $sformatf("R%0d vec%0d", v[3:0], i);
      drive(v[103], v[102], v[101:70]);
      @(negedge clk);
      check({tg, " irq"}, {31'd0, irq}, {31'd0, v[69]});
      check({tg, " ack"}, {31'd0, swap_ack}, {31'd0, v[68]});
      check({tg, " isr_word"}, isr_word, v[67:36]);
      if (v[68]) check({tg, " old"}, swap_old, v[35:4]);
    end
    drive(1'b0, 1'b0, 32'd0);
    @(negedge clk);
    // R3 ack drops when request stops
    check("R3 ack low after idle", {31'd0, swap_ack}, 32'd0);

    // R1 asynchronous drop while pending
    check("R1 pending before reset", {31'd0, irq}, 32'd1);
    #1 rst_n = 1'b0;
    #0.5;
    check("R1 async irq drop", {31'd0, irq}, 32'd0);
    check("R1 async word drop", isr_word, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    drive(1'b1, 1'b0, 32'h0BAD_F00D);
    @(negedge clk);
    drive(1'b0, 1'b0, 32'd0);
    check("R2 post after reset", isr_word, 32'h0BAD_F00D);
    check("R4 post after reset old", swap_old, 32'd0);
    // R7 final clear
    drive(1'b0, 1'b1, 32'd0);
    @(negedge clk);
    drive(1'b0, 1'b0, 32'd0);
    check("R7 final clear irq", {31'd0, irq}, 32'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule